// File: doc/BRIEF.md
# Speculative Branch History Queue

This block keeps, for one hardware thread, an ordered record of the branch predictions that are still in flight. Each time the front end makes a prediction, taken or not, it pushes one record at the young end. The record holds the sequence number, the branch PC, the predicted direction, the thread id and the repair state the return-address stack needs. When branches commit, a commit request retires records from the old end. Each retired record either trains the direction predictor or, if it was already corrected, only reports its retirement. When a branch mispredicts, a squash request discards records from the young end. Each discarded record drives the repair of the return-address stack.

Commit and squash are walks of one record per cycle. A walk begins with a one-cycle command handshake on its own valid/ready port. While a walk runs, all three input ports hold ready low. Pushes are also refused while the queue holds its full depth. The upstream stage keeps its valid high, with stable data, until the cycle in which ready is high. All results leave as registered one-cycle strobes that share one payload bus.

Top module: `bhq_top`

## Requirements
- R1: After reset the queue is empty. `full` is 0, `push_ready`, `cm_ready` and `sq_ready` are 1, and every event strobe is 0.
- R2: A push is accepted on a clock edge where `push_valid` and `push_ready` are both high, and it appends at the young end. `full` rises once DEPTH records are held, and `push_ready` is then low. A push offered while `push_ready` is low leaves the queue unchanged.
- R3: A commit with sequence number N retires the oldest record, one per cycle, for as long as the oldest sequence number is ≤ N (unsigned). Records leave oldest first. The first event is registered on the edge after the command is accepted.
- R4: Retiring a record that is not marked squashed pulses `train_valid`. The payload carries that record's sequence number, PC, predicted direction on `ev_taken`, thread id and flags.
- R5: Retiring a record that is marked squashed pulses `retsq_valid` and not `train_valid`.
- R6: A squash with sequence number N removes the youngest record, one per cycle, for as long as the youngest sequence number is > N. Each removal pulses `drop_valid` with that record's payload, youngest first.
- R7: A removed record whose return-stack-used flag (`ev_flags` bit 0) is set also pulses `rs_restore`, with its saved stack index on `ev_rs_idx` and its saved stack value on `ev_rs_val`.
- R8: A removed record without bit 0 set, but with both the call flag (bit 1) and the stack-pushed flag (bit 2) set, pulses `rs_pop`. Any other removed record pulses neither repair strobe. Bit 3 is the return flag and bit 4 the indirect flag.
- R9: When a squash has `sq_mispred` set and records remain after its removals, the walk's final edge marks the youngest remaining record as squashed. It pulses `fix_valid` with that record's payload and with `ev_taken` set to `sq_taken`. The youngest remaining record must carry sequence number N.
- R10: A mispredict squash that leaves, or finds, the queue empty produces no `fix_valid`.
- R11: While a walk runs, `sq_ready`, `cm_ready` and `push_ready` are low. When a squash and a commit are offered in the same idle cycle, the squash is accepted.
- R12: At most one of `train_valid`, `retsq_valid`, `drop_valid` and `fix_valid` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push_valid | input | 1 | Prediction record offered |
| push_ready | output | 1 | Queue can take a record this cycle |
| push_seq | input | SEQ_W | Sequence number of the predicted branch |
| push_pc | input | PC_W | Branch PC |
| push_taken | input | 1 | Predicted direction |
| push_tid | input | TID_W | Thread id |
| push_rs_used | input | 1 | Prediction took its target from the return stack |
| push_rs_idx | input | RSI_W | Saved return-stack top index |
| push_rs_val | input | PC_W | Saved return-stack top value |
| push_call | input | 1 | Branch is a call |
| push_rs_pushed | input | 1 | Call pushed the return stack |
| push_ret | input | 1 | Branch is a return |
| push_ind | input | 1 | Branch is indirect |
| full | output | 1 | Queue holds DEPTH records |
| cm_valid | input | 1 | Commit request |
| cm_ready | output | 1 | Commit request accepted this cycle |
| cm_seq | input | SEQ_W | Youngest committed sequence number |
| sq_valid | input | 1 | Squash request |
| sq_ready | output | 1 | Squash request accepted this cycle |
| sq_seq | input | SEQ_W | Sequence number of the surviving branch |
| sq_mispred | input | 1 | Squash is caused by a mispredict of branch sq_seq |
| sq_taken | input | 1 | Actual direction of the mispredicted branch |
| train_valid | output | 1 | Retired record trains the predictor |
| retsq_valid | output | 1 | Retired record was already corrected |
| drop_valid | output | 1 | Record discarded by a squash |
| rs_restore | output | 1 | Restore return-stack top from payload |
| rs_pop | output | 1 | Pop the return stack once |
| fix_valid | output | 1 | Retrain the mispredicted record |
| ev_seq | output | SEQ_W | Event record sequence number |
| ev_pc | output | PC_W | Event record PC |
| ev_taken | output | 1 | Direction for training |
| ev_tid | output | TID_W | Event record thread id |
| ev_flags | output | 5 | {indirect, return, pushed, call, used} |
| ev_rs_idx | output | RSI_W | Saved return-stack index |
| ev_rs_val | output | PC_W | Saved return-stack value |

## Verification
Take the edge that accepts a command as edge k. The event for the j-th record handled by the walk is registered on edge k+1+j. When the walk has handled n records, edge k+1+n ends it: that edge raises `sq_ready` again and, for a mispredict squash, registers `fix_valid`. The bench computes each command's ordered list of expected events from its own model of the queue. It then samples the outputs at the falling edge after each of those n+1 rising edges. A quiet cycle, a late event or ready coming back one cycle early or late is reported like a wrong payload. A push shows its effect through `full` and `push_ready` after the accepting edge. A refused push shows up only in the retire events of a later commit, so the bench checks those.

// File: rtl/bhq_pkg.sv
package bhq_pkg;
  typedef enum logic [1:0] {WK_IDLE, WK_COMMIT, WK_SQUASH} walk_e;
  localparam int FL_USED_RS = 0;
  localparam int FL_CALL    = 1;
  localparam int FL_PUSHED  = 2;
  localparam int FL_RET     = 3;
  localparam int FL_IND     = 4;
  localparam int NFLAGS     = 5;
endpackage

// File: rtl/bhq_ring.sv
// Circular record store: appends and drops at the young end, drops at the old end,
// and keeps a per-slot corrected mark.
module bhq_ring #(
  parameter int DEPTH = 16,
  parameter int W     = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push_en,
  input  logic [W-1:0] push_rec,
  input  logic         pop_old,
  input  logic         pop_young,
  input  logic         mark_young,
  output logic [W-1:0] old_rec,
  output logic [W-1:0] young_rec,
  output logic         old_sq,
  output logic         young_sq,
  output logic         empty,
  output logic         full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [W-1:0]     mem [DEPTH];
  logic [DEPTH-1:0] sq_vec;
  logic [PTR_W-1:0] head, tail, yng;
  logic [CNT_W-1:0] cnt;

  function automatic logic [PTR_W-1:0] step_up(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : PTR_W'(p + 1'b1);
  endfunction

  function automatic logic [PTR_W-1:0] step_dn(input logic [PTR_W-1:0] p);
    return (p == '0) ? PTR_W'(DEPTH - 1) : PTR_W'(p - 1'b1);
  endfunction

  assign yng = step_dn(tail);

  always_ff @(posedge clk) begin
    if (push_en) mem[tail] <= push_rec;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head <= '0;
      tail <= '0;
      cnt  <= '0;
    end else begin
      if (pop_old)        head <= step_up(head);
      if (push_en)        tail <= step_up(tail);
      else if (pop_young) tail <= yng;
      cnt <= cnt + CNT_W'(push_en) - CNT_W'(pop_old) - CNT_W'(pop_young);
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic mark;
    always_ff @(posedge clk) begin
      if (!rst_n)                                    mark <= 1'b0;
      else if (push_en && tail == PTR_W'(i))         mark <= 1'b0;
      else if (mark_young && yng == PTR_W'(i))       mark <= 1'b1;
    end
    assign sq_vec[i] = mark;
  end

  assign old_rec   = mem[head];
  assign young_rec = mem[yng];
  assign old_sq    = sq_vec[head];
  assign young_sq  = sq_vec[yng];
  assign empty     = (cnt == '0);
  assign full      = (cnt == CNT_W'(DEPTH));
endmodule

// File: rtl/bhq_walk.sv
// Command sequencer: one record per cycle from the chosen end until the compare fails.
module bhq_walk
  import bhq_pkg::*;
#(
  parameter int SEQ_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sq_valid,
  input  logic [SEQ_W-1:0] sq_seq,
  input  logic             sq_mispred,
  input  logic             sq_taken,
  input  logic             cm_valid,
  input  logic [SEQ_W-1:0] cm_seq,
  input  logic             empty,
  input  logic [SEQ_W-1:0] old_seq,
  input  logic [SEQ_W-1:0] young_seq,
  output logic             idle,
  output logic             pop_old,
  output logic             pop_young,
  output logic             mark_young,
  output logic             act_taken
);
  walk_e            st;
  logic [SEQ_W-1:0] tgt;
  logic             misp;

  assign idle = (st == WK_IDLE);

  always_comb begin
    pop_old    = 1'b0;
    pop_young  = 1'b0;
    mark_young = 1'b0;
    case (st)
      WK_COMMIT: pop_old = !empty && (old_seq <= tgt);
      WK_SQUASH: begin
        pop_young  = !empty && (young_seq > tgt);
        mark_young = !pop_young && misp && !empty;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= WK_IDLE;
      tgt       <= '0;
      misp      <= 1'b0;
      act_taken <= 1'b0;
    end else begin
      case (st)
        WK_IDLE: begin
          if (sq_valid) begin
            st        <= WK_SQUASH;
            tgt       <= sq_seq;
            misp      <= sq_mispred;
            act_taken <= sq_taken;
          end else if (cm_valid) begin
            st  <= WK_COMMIT;
            tgt <= cm_seq;
          end
        end
        WK_COMMIT: if (!pop_old)   st <= WK_IDLE;
        WK_SQUASH: if (!pop_young) st <= WK_IDLE;
        default:   st <= WK_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/bhq_top.sv
module bhq_top
  import bhq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int SEQ_W = 16,
  parameter int PC_W  = 32,
  parameter int TID_W = 2,
  parameter int RSI_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_valid,
  output logic             push_ready,
  input  logic [SEQ_W-1:0] push_seq,
  input  logic [PC_W-1:0]  push_pc,
  input  logic             push_taken,
  input  logic [TID_W-1:0] push_tid,
  input  logic             push_rs_used,
  input  logic [RSI_W-1:0] push_rs_idx,
  input  logic [PC_W-1:0]  push_rs_val,
  input  logic             push_call,
  input  logic             push_rs_pushed,
  input  logic             push_ret,
  input  logic             push_ind,
  output logic             full,
  input  logic             cm_valid,
  output logic             cm_ready,
  input  logic [SEQ_W-1:0] cm_seq,
  input  logic             sq_valid,
  output logic             sq_ready,
  input  logic [SEQ_W-1:0] sq_seq,
  input  logic             sq_mispred,
  input  logic             sq_taken,
  output logic             train_valid,
  output logic             retsq_valid,
  output logic             drop_valid,
  output logic             rs_restore,
  output logic             rs_pop,
  output logic             fix_valid,
  output logic [SEQ_W-1:0] ev_seq,
  output logic [PC_W-1:0]  ev_pc,
  output logic             ev_taken,
  output logic [TID_W-1:0] ev_tid,
  output logic [NFLAGS-1:0] ev_flags,
  output logic [RSI_W-1:0] ev_rs_idx,
  output logic [PC_W-1:0]  ev_rs_val
);
  localparam int OFF_FL  = 0;
  localparam int OFF_RSV = OFF_FL + NFLAGS;
  localparam int OFF_RSI = OFF_RSV + PC_W;
  localparam int OFF_TID = OFF_RSI + RSI_W;
  localparam int OFF_TKN = OFF_TID + TID_W;
  localparam int OFF_PC  = OFF_TKN + 1;
  localparam int OFF_SEQ = OFF_PC + PC_W;
  localparam int REC_W   = OFF_SEQ + SEQ_W;

  logic [REC_W-1:0] in_rec, old_rec, young_rec, ev_rec;
  logic old_sq, young_sq, empty, idle, push_en;
  logic pop_old, pop_young, mark_young, act_taken;

  assign in_rec = {push_seq, push_pc, push_taken, push_tid, push_rs_idx, push_rs_val,
                   push_ind, push_ret, push_rs_pushed, push_call, push_rs_used};

  assign push_ready = idle && !full;
  assign push_en    = push_valid && push_ready;
  assign sq_ready   = idle;
  assign cm_ready   = idle && !sq_valid;

  bhq_ring #(.DEPTH(DEPTH), .W(REC_W)) u_ring (
    .clk, .rst_n, .push_en, .push_rec(in_rec), .pop_old, .pop_young, .mark_young,
    .old_rec, .young_rec, .old_sq, .young_sq, .empty, .full
  );

  bhq_walk #(.SEQ_W(SEQ_W)) u_walk (
    .clk, .rst_n, .sq_valid, .sq_seq, .sq_mispred, .sq_taken, .cm_valid, .cm_seq,
    .empty,
    .old_seq(old_rec[OFF_SEQ +: SEQ_W]),
    .young_seq(young_rec[OFF_SEQ +: SEQ_W]),
    .idle, .pop_old, .pop_young, .mark_young, .act_taken
  );

  logic y_used, y_call, y_pushed;
  assign y_used   = young_rec[OFF_FL + FL_USED_RS];
  assign y_call   = young_rec[OFF_FL + FL_CALL];
  assign y_pushed = young_rec[OFF_FL + FL_PUSHED];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      train_valid <= 1'b0;
      retsq_valid <= 1'b0;
      drop_valid  <= 1'b0;
      rs_restore  <= 1'b0;
      rs_pop      <= 1'b0;
      fix_valid   <= 1'b0;
      ev_rec      <= '0;
      ev_taken    <= 1'b0;
    end else begin
      train_valid <= pop_old && !old_sq;
      retsq_valid <= pop_old && old_sq;
      drop_valid  <= pop_young;
      rs_restore  <= pop_young && y_used;
      rs_pop      <= pop_young && !y_used && y_call && y_pushed;
      fix_valid   <= mark_young;
      if (pop_old) begin
        ev_rec   <= old_rec;
        ev_taken <= old_rec[OFF_TKN];
      end else if (pop_young || mark_young) begin
        ev_rec   <= young_rec;
        ev_taken <= mark_young ? act_taken : young_rec[OFF_TKN];
      end
    end
  end

  assign ev_seq    = ev_rec[OFF_SEQ +: SEQ_W];
  assign ev_pc     = ev_rec[OFF_PC  +: PC_W];
  assign ev_tid    = ev_rec[OFF_TID +: TID_W];
  assign ev_rs_idx = ev_rec[OFF_RSI +: RSI_W];
  assign ev_rs_val = ev_rec[OFF_RSV +: PC_W];
  assign ev_flags  = ev_rec[OFF_FL  +: NFLAGS];
endmodule

// File: rtl/bhq_check.sv
module bhq_check (
  input logic clk,
  input logic rst_n,
  input logic push_ready,
  input logic full,
  input logic cm_ready,
  input logic sq_ready,
  input logic train_valid,
  input logic retsq_valid,
  input logic drop_valid,
  input logic rs_restore,
  input logic rs_pop,
  input logic fix_valid
);
  AST_ONE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({train_valid, retsq_valid, drop_valid, fix_valid})); // R12
  AST_FULL_STALLS_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !push_ready); // R2
  AST_WALK_BLOCKS_PORTS: assert property (@(posedge clk) disable iff (!rst_n)
    !sq_ready |-> (!cm_ready && !push_ready)); // R11
  AST_REPAIR_NEEDS_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_restore || rs_pop) |-> drop_valid); // R7
  AST_REPAIR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(rs_restore && rs_pop)); // R8
  AST_FIX_ENDS_WALK: assert property (@(posedge clk) disable iff (!rst_n)
    fix_valid |-> sq_ready); // R9
  AST_RETIRE_IN_WALK: assert property (@(posedge clk) disable iff (!rst_n)
    (train_valid || retsq_valid || drop_valid) |-> !$past(sq_ready)); // R3
endmodule

bind bhq_top bhq_check u_bhq_check (
  .clk(clk), .rst_n(rst_n), .push_ready(push_ready), .full(full),
  .cm_ready(cm_ready), .sq_ready(sq_ready), .train_valid(train_valid),
  .retsq_valid(retsq_valid), .drop_valid(drop_valid), .rs_restore(rs_restore),
  .rs_pop(rs_pop), .fix_valid(fix_valid)
);

// File: tb/tb_bhq_top.sv
`timescale 1ns/1ps
module tb_bhq_top;
  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic push_valid = 0, push_taken = 0, push_rs_used = 0, push_call = 0;
  logic push_rs_pushed = 0, push_ret = 0, push_ind = 0;
  logic [15:0] push_seq = 0; logic [31:0] push_pc = 0, push_rs_val = 0;
  logic [1:0] push_tid = 0; logic [3:0] push_rs_idx = 0;
  logic cm_valid = 0, sq_valid = 0, sq_mispred = 0, sq_taken = 0;
  logic [15:0] cm_seq = 0, sq_seq = 0;
  logic push_ready, full, cm_ready, sq_ready;
  logic train_valid, retsq_valid, drop_valid, rs_restore, rs_pop, fix_valid, ev_taken;
  logic [15:0] ev_seq; logic [31:0] ev_pc, ev_rs_val; logic [1:0] ev_tid;
  logic [4:0] ev_flags; logic [3:0] ev_rs_idx;

  bhq_top dut (.*);

  int errors = 0, checks = 0;
  // model, slot 0 is the oldest record
  logic [15:0] m_seq [16]; logic [31:0] m_pc [16]; logic [31:0] m_val [16];
  logic m_tk [16]; logic m_sq [16]; logic [1:0] m_tid [16];
  logic [4:0] m_fl [16]; logic [3:0] m_idx [16];
  int m_n = 0;
  int next_seq = 10;
  // expected events of one command
  int e_kind [18]; logic [15:0] e_seq [18]; logic [31:0] e_pc [18];
  logic [31:0] e_val [18]; logic e_tk [18]; logic [1:0] e_tid [18];
  logic [4:0] e_fl [18]; logic [3:0] e_idx [18];
  int e_n;

  function automatic int drop_kind(input logic [4:0] fl);
    if (fl[0]) return 3;
    if (fl[1] && fl[2]) return 4;
    return 5;
  endfunction

  function automatic string tag_of(input int k, input bit is_sq, input bit mis);
    case (k)
      1: return "R4"; 2: return "R5"; 3: return "R7"; 4: return "R8";
      5: return "R6"; 6: return "R9";
      default: return is_sq ? (mis ? "R10" : "R6") : "R3";
    endcase
  endfunction

  task automatic add_exp(input int k, input int s, input logic tk);
    e_kind[e_n] = k; e_seq[e_n] = m_seq[s]; e_pc[e_n] = m_pc[s];
    e_val[e_n] = m_val[s]; e_tk[e_n] = tk; e_tid[e_n] = m_tid[s];
    e_fl[e_n] = m_fl[s]; e_idx[e_n] = m_idx[s]; e_n++;
  endtask

  task automatic check(input bit ok, input string req, input string what);
    checks++;
    if (!ok) begin errors++; $display("FAIL %s %s", req, what); end
  endtask

  task automatic do_push(input bit expect_accept);
    @(negedge clk);
    push_valid = 1; push_seq = 16'(next_seq); push_pc = $urandom;
    push_taken = 1'($urandom); push_tid = 2'($urandom); push_rs_used = 1'($urandom);
    push_rs_idx = 4'($urandom); push_rs_val = $urandom; push_call = 1'($urandom);
    push_rs_pushed = 1'($urandom); push_ret = 1'($urandom); push_ind = 1'($urandom);
    check(push_ready == expect_accept, "R2",
          $sformatf("push_ready act=%0d exp=%0d", push_ready, expect_accept));
    if (expect_accept) begin
      m_seq[m_n] = push_seq; m_pc[m_n] = push_pc; m_tk[m_n] = push_taken;
      m_tid[m_n] = push_tid; m_idx[m_n] = push_rs_idx; m_val[m_n] = push_rs_val;
      m_fl[m_n] = {push_ind, push_ret, push_rs_pushed, push_call, push_rs_used};
      m_sq[m_n] = 0; m_n++;
      next_seq += 1 + int'($urandom % 3);
    end
    @(posedge clk); #1 push_valid = 0;
  endtask

  // run one command whose expected events are in e_*; w = walk length before end
  task automatic run_cmd(input bit is_sq, input bit also_cm, input logic [15:0] n,
                         input bit mis, input bit act, input int w, input bit fix);
    @(negedge clk);
    check(sq_ready && (cm_ready || is_sq), "R11", "command port not ready when idle");
    if (is_sq) begin sq_valid = 1; sq_seq = n; sq_mispred = mis; sq_taken = act; end
    if (!is_sq || also_cm) begin cm_valid = 1; cm_seq = also_cm ? 16'hffff : n; end
    @(posedge clk); #1 sq_valid = 0; cm_valid = 0;
    for (int j = 0; j <= w; j++) begin
      int ak, xk, cnt;
      bit ok;
      @(posedge clk); @(negedge clk);
      xk = (j < w) ? e_kind[j] : (fix ? 6 : 0);
      cnt = int'(train_valid) + int'(retsq_valid) + int'(drop_valid) + int'(fix_valid);
      ak = (cnt > 1) ? 99 : train_valid ? 1 : retsq_valid ? 2 :
           (drop_valid && rs_restore) ? 3 : (drop_valid && rs_pop) ? 4 :
           drop_valid ? 5 : fix_valid ? 6 : 0;
      ok = (ak == xk) && (sq_ready == (j == w)) && (push_ready == ((j == w) && (m_n < 16)));
      if (ok && xk != 0) begin
        ok = (ev_seq == e_seq[j]) && (ev_pc == e_pc[j]) && (ev_flags == e_fl[j]) &&
             (ev_tid == e_tid[j]);
        if (xk == 1 || xk == 6) ok = ok && (ev_taken == e_tk[j]);
        if (xk == 3) ok = ok && (ev_rs_idx == e_idx[j]) && (ev_rs_val == e_val[j]);
      end
      check(ok, tag_of(xk, is_sq, mis),
            $sformatf("step %0d: kind=%0d seq=%h pc=%h tk=%0d rdy=%0d exp kind=%0d seq=%h pc=%h tk=%0d rdy=%0d",
                      j, ak, ev_seq, ev_pc, ev_taken, sq_ready, xk,
                      (xk != 0) ? e_seq[j] : 16'h0, (xk != 0) ? e_pc[j] : 32'h0,
                      (xk != 0) ? e_tk[j] : 1'b0, (j == w)));
    end
  endtask

  task automatic do_commit(input logic [15:0] n);
    e_n = 0;
    while (m_n > 0 && m_seq[0] <= n) begin
      add_exp(m_sq[0] ? 2 : 1, 0, m_tk[0]);
      for (int i = 0; i < 15; i++) begin
        m_seq[i] = m_seq[i+1]; m_pc[i] = m_pc[i+1]; m_tk[i] = m_tk[i+1];
        m_sq[i] = m_sq[i+1]; m_tid[i] = m_tid[i+1]; m_fl[i] = m_fl[i+1];
        m_idx[i] = m_idx[i+1]; m_val[i] = m_val[i+1];
      end
      m_n--;
    end
    run_cmd(0, 0, n, 0, 0, e_n, 0);
  endtask

  task automatic do_squash(input logic [15:0] n, input bit mis, input bit act, input bit also_cm);
    int w;
    bit fx;
    e_n = 0;
    while (m_n > 0 && m_seq[m_n-1] > n) begin
      add_exp(drop_kind(m_fl[m_n-1]), m_n - 1, m_tk[m_n-1]);
      m_n--;
    end
    w = e_n; fx = mis && (m_n > 0);
    if (fx) begin add_exp(6, m_n - 1, act); m_sq[m_n-1] = 1; end
    run_cmd(1, also_cm, n, mis, act, w, fx);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not end, act=running exp=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd7341));
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    check(!full && push_ready && cm_ready && sq_ready &&
          !(train_valid || retsq_valid || drop_valid || fix_valid || rs_restore || rs_pop),
          "R1", $sformatf("reset state full=%0d pr=%0d cr=%0d sr=%0d", full, push_ready,
                          cm_ready, sq_ready));
    // R2: fill, refuse a push while full, then commit everything
    for (int i = 0; i < 16; i++) do_push(1);
    @(negedge clk);
    check(full && !push_ready, "R2", $sformatf("full=%0d push_ready=%0d exp 1/0", full, push_ready));
    do_push(0);
    do_commit(16'hffff);
    // R10: mispredict squash on an empty queue
    do_squash(16'd5, 1, 1, 0);
    // R9/R5: mispredict in the middle, then retire the corrected record
    for (int i = 0; i < 6; i++) do_push(1);
    do_squash(m_seq[2], 1, ~m_tk[2], 0);
    do_commit(16'hffff);
    // R10: mispredict squash that empties the queue
    for (int i = 0; i < 3; i++) do_push(1);
    do_squash(16'(m_seq[0] - 1), 1, 0, 0);
    // R11: squash and commit offered together, squash wins
    for (int i = 0; i < 4; i++) do_push(1);
    do_squash(m_seq[1], 0, 0, 1);
    do_commit(16'hffff);
    // random mix
    for (int it = 0; it < 700; it++) begin
      int op;
      op = int'($urandom % 8);
      if (op < 4 && m_n < 16) do_push(1);
      else if (op < 6 || m_n == 0) begin
        int lo, span;
        lo = (m_n > 0) ? int'(m_seq[0]) : next_seq;
        span = (m_n > 0) ? int'(m_seq[m_n-1]) - lo + 3 : 2;
        do_commit(16'(lo - 1 + int'($urandom % span)));
      end else begin
        int k, md;
        k = int'($urandom % m_n);
        md = int'($urandom % 4);
        if (md == 3) do_squash(16'(m_seq[0] - 1), 1, 1'($urandom), 0);
        else do_squash(m_seq[k], md != 2, 1'($urandom), 0);
      end
    end
    do_commit(16'hffff);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule